// File: doc/BRIEF.md
# Interrupt-Driven Byte Serial Port for an 8-bit CPU I/O Bus

This block sits on the I/O side of an 8-bit CPU bus and offers software a byte-wide serial channel through two I/O ports: a status port at address 0x80 and a data port at 0x81. Only the low address byte matters. The bit-level line interface is handled elsewhere. On its far side the block takes a stream of received bytes, each with a valid strobe, and emits a stream of transmitted bytes, each with a valid strobe.

Every received byte is latched into a one-byte holding register and marks an interrupt as pending. The active-low interrupt request stays asserted until the CPU runs an interrupt acknowledge cycle. During that cycle the block places a configurable vector byte on the data bus, so a vectored interrupt mode can be used. In a fixed-address interrupt mode the CPU simply ignores the byte.

The bus strobes are asynchronous to the block clock and pass through a synchronizer. Each qualified strobe combination is acted on once, on its leading edge. The data bus is modelled as a separate output byte plus an output enable.

Top module: `iobus_serial_port`

## Requirements
- R1: A read of port 0x80 drives the status byte. Bit 1 (transmit ready) and bit 0 (receive data available) are always 1. Bits 6 to 2 are always 0. Bit 7 is the overrun flag.
- R2: A read of port 0x81 drives the most recently received byte.
- R3: A write to port 0x81 produces exactly one single-cycle transmit valid pulse, carrying the written byte.
- R4: A received byte sets the interrupt pending. The interrupt output stays low for any number of cycles until an acknowledge occurs.
- R5: An acknowledge cycle clears the pending interrupt and releases the interrupt output. An acknowledge cycle is IORQ and M1 both low. If a byte arrives in the same cycle that the acknowledge is acted on, the new byte wins: the interrupt stays pending, the byte is stored, and no overrun is flagged.
- R6: During an acknowledge cycle the output enable is high and the data output carries the vector register. The vector register resets to 0xFF and is loaded from the configuration input when the load strobe is high.
- R7: The output enable is high only during a read of port 0x80 or 0x81, or during an acknowledge. It is low in every other case, including reads of other addresses and all writes.
- R8: A byte that arrives while an interrupt is still pending overwrites the holding register and sets the overrun flag. A read of port 0x81 clears the overrun flag, unless a new overrun is set in the same cycle.
- R9: A strobe combination held for many cycles is acted on only once. The output enable rises on the second clock edge after the strobes assert. The effect of the access (a transmit pulse, a flag cleared) happens on the third clock edge.
- R10: A write to port 0x80 is ignored. It produces no transmit pulse and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iorq_n_i | input | 1 | I/O request strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| m1_n_i | input | 1 | Opcode-fetch / acknowledge marker, active low |
| addr_i | input | 8 | Low byte of the address bus |
| data_i | input | 8 | Data bus as driven by the CPU |
| data_o | output | 8 | Byte this block drives onto the data bus |
| data_oe_o | output | 1 | Enable for data_o; bus is released when low |
| int_n_o | output | 1 | Maskable interrupt request, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| vec_load_i | input | 1 | Loads the vector register |
| vec_i | input | 8 | New vector value |

## Verification
Two functions can fall in the same clock cycle: the acknowledge event that clears the pending interrupt, and a byte arriving that sets it again. The bench provokes this race by raising the receive strobe in exactly the cycle in which the synchronized acknowledge is registered. It then judges the outcome at the ports. The interrupt must still be low, a data read must return the new byte, and the status byte must show no overrun. Random traffic also mixes arrivals with pending interrupts and data reads, to exercise overrun set against overrun clear.

// File: rtl/iobus_serial_pkg.sv
`timescale 1ns/1ps
package iobus_serial_pkg;

    // One bit per qualified bus cycle kind
    typedef struct packed {
        logic rd;   // I/O read, not an acknowledge
        logic wr;   // I/O write
        logic ack;  // interrupt acknowledge
    } bus_cyc_t;

    // Pin positions inside the synchronizer chain
    localparam int PIN_IORQ = 0;
    localparam int PIN_RD   = 1;
    localparam int PIN_WR   = 2;
    localparam int PIN_M1   = 3;
    localparam int PIN_CNT  = 4;

endpackage

// File: rtl/iobus_strobe_sync.sv
`timescale 1ns/1ps
module iobus_strobe_sync
    import iobus_serial_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     iorq_n_i,
    input  logic     rd_n_i,
    input  logic     wr_n_i,
    input  logic     m1_n_i,
    output bus_cyc_t lvl_o,
    output bus_cyc_t evt_o
);

    typedef struct packed {
        logic [STAGES-1:0][PIN_CNT-1:0] chain;
        bus_cyc_t                       prev;
    } sync_st_t;

    sync_st_t s_d, s_q;
    logic [PIN_CNT-1:0] pins_s;

    assign pins_s = s_q.chain[STAGES-1];

    // Qualified cycle levels from synchronized pins
    assign lvl_o.rd  = !pins_s[PIN_IORQ] && !pins_s[PIN_RD] && pins_s[PIN_M1];
    assign lvl_o.wr  = !pins_s[PIN_IORQ] && !pins_s[PIN_WR] && pins_s[PIN_M1];
    assign lvl_o.ack = !pins_s[PIN_IORQ] && !pins_s[PIN_M1];

    // Leading-edge events: one cycle per strobe assertion
    assign evt_o = bus_cyc_t'(lvl_o & ~s_q.prev);

    always_comb begin
        s_d = s_q;
        s_d.chain[0][PIN_IORQ] = iorq_n_i;
        s_d.chain[0][PIN_RD]   = rd_n_i;
        s_d.chain[0][PIN_WR]   = wr_n_i;
        s_d.chain[0][PIN_M1]   = m1_n_i;
        s_d.prev = lvl_o;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                s_q.chain[g] <= '1;
            end else begin
                s_q.chain[g] <= s_q.chain[g-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.chain[0] <= '1;
            s_q.prev     <= '0;
        end else begin
            s_q.chain[0] <= s_d.chain[0];
            s_q.prev     <= s_d.prev;
        end
    end

    AST_RD_ONCE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o.rd |=> !evt_o.rd);    // R9
    AST_WR_ONCE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o.wr |=> !evt_o.wr);    // R9
    AST_ACK_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o.ack |=> !evt_o.ack);  // R9

endmodule

// File: rtl/iobus_rx_hold.sv
`timescale 1ns/1ps
module iobus_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              ack_evt_i,
    input  logic              ovr_clr_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              pend_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              pend;
        logic              ovr;
    } rx_st_t;

    rx_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // Clears first, then arrivals, so a same-cycle arrival wins
        if (ack_evt_i) begin
            s_d.pend = 1'b0;
        end
        if (ovr_clr_i) begin
            s_d.ovr = 1'b0;
        end
        if (rx_valid_i) begin
            s_d.hold = rx_data_i;
            s_d.pend = 1'b1;
            if (s_q.pend && !ack_evt_i) begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_o  = s_q.hold;
    assign pend_o = s_q.pend;
    assign ovr_o  = s_q.ovr;

    AST_RX_CAPTURE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |=> (pend_o && buf_o == $past(rx_data_i)));   // R2
    AST_INT_HOLD:    assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !ack_evt_i) |=> pend_o);                      // R4
    AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_evt_i && !rx_valid_i) |=> !pend_o);                 // R5
    AST_ACK_RX_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_evt_i && rx_valid_i && !ovr_clr_i) |=> (pend_o && ovr_o == $past(ovr_o))); // R5
    AST_OVR_SET:     assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && pend_o && !ack_evt_i) |=> ovr_o);         // R8

endmodule

// File: rtl/iobus_tx_vec.sv
`timescale 1ns/1ps
module iobus_tx_vec #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] VEC_RESET = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              send_i,
    input  logic [DATA_W-1:0] send_data_i,
    input  logic              vec_load_i,
    input  logic [DATA_W-1:0] vec_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic [DATA_W-1:0] vec_o
);

    typedef struct packed {
        logic              txv;
        logic [DATA_W-1:0] txd;
        logic [DATA_W-1:0] vec;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.txv = send_i;
        if (send_i) begin
            s_d.txd = send_data_i;
        end
        if (vec_load_i) begin
            s_d.vec = vec_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.txv <= 1'b0;
            s_q.txd <= '0;
            s_q.vec <= VEC_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = s_q.txv;
    assign tx_data_o  = s_q.txd;
    assign vec_o      = s_q.vec;

    AST_TX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o |=> !tx_valid_o);                         // R3
    AST_TX_DATA:   assert property (@(posedge clk_i) disable iff (!rst_ni)
        send_i |=> (tx_valid_o && tx_data_o == $past(send_data_i))); // R3
    AST_VEC_LOAD:  assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_load_i |=> (vec_o == $past(vec_i)));             // R6

endmodule

// File: rtl/iobus_serial_port.sv
`timescale 1ns/1ps
module iobus_serial_port
    import iobus_serial_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h80,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h81,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] VEC_RESET   = 8'hFF,
    parameter logic [DATA_W-2:0] STATUS_LOW  = 7'h03
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              iorq_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              m1_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              int_n_o,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              vec_load_i,
    input  logic [DATA_W-1:0] vec_i
);

    bus_cyc_t          cyc_lvl, cyc_evt;
    logic              hit_status, hit_data;
    logic              ovr_clr, send;
    logic [DATA_W-1:0] rx_buf, vec;
    logic              pend, ovr;
    logic [DATA_W-1:0] status_byte;

    iobus_strobe_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .iorq_n_i (iorq_n_i),
        .rd_n_i   (rd_n_i),
        .wr_n_i   (wr_n_i),
        .m1_n_i   (m1_n_i),
        .lvl_o    (cyc_lvl),
        .evt_o    (cyc_evt)
    );

    assign hit_status = (addr_i == STATUS_ADDR);
    assign hit_data   = (addr_i == DATA_ADDR);
    assign ovr_clr    = cyc_evt.rd && hit_data;
    assign send       = cyc_evt.wr && hit_data;

    iobus_rx_hold #(
        .DATA_W (DATA_W)
    ) i_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .ack_evt_i  (cyc_evt.ack),
        .ovr_clr_i  (ovr_clr),
        .buf_o      (rx_buf),
        .pend_o     (pend),
        .ovr_o      (ovr)
    );

    iobus_tx_vec #(
        .DATA_W    (DATA_W),
        .VEC_RESET (VEC_RESET)
    ) i_tx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .send_i      (send),
        .send_data_i (data_i),
        .vec_load_i  (vec_load_i),
        .vec_i       (vec_i),
        .tx_valid_o  (tx_valid_o),
        .tx_data_o   (tx_data_o),
        .vec_o       (vec)
    );

    assign status_byte = {ovr, STATUS_LOW};

    // Bus drive selection
    always_comb begin
        data_oe_o = 1'b0;
        data_o    = '0;
        if (cyc_lvl.ack) begin
            data_oe_o = 1'b1;
            data_o    = vec;
        end else if (cyc_lvl.rd && hit_data) begin
            data_oe_o = 1'b1;
            data_o    = rx_buf;
        end else if (cyc_lvl.rd && hit_status) begin
            data_oe_o = 1'b1;
            data_o    = status_byte;
        end
    end

    assign int_n_o = !pend;

    AST_ACK_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_lvl.ack |-> (data_oe_o && data_o == vec));            // R6
    AST_BUS_QUIET:  assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cyc_lvl.rd && !cyc_lvl.ack) |-> !data_oe_o);            // R7
    AST_STATUS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_lvl.rd && hit_status) |-> (data_o[1:0] == 2'b11));    // R1

endmodule

// File: tb/test_iobus_serial_port.sv
`timescale 1ns/1ps
module test_iobus_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic [7:0] addr = 8'h00, din = 8'h00;
    logic [7:0] dout;
    logic       oe, int_n;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       vec_load = 1'b0;
    logic [7:0] vec_in = 8'h00;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench model state
    logic [7:0] m_buf = 8'h00;
    logic       m_pend = 1'b0;
    logic       m_ovr = 1'b0;
    logic [7:0] m_vec = 8'hFF;

    always #2 clk = ~clk;

    iobus_serial_port i_iobus_serial_port (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .iorq_n_i   (iorq_n),
        .rd_n_i     (rd_n),
        .wr_n_i     (wr_n),
        .m1_n_i     (m1_n),
        .addr_i     (addr),
        .data_i     (din),
        .data_o     (dout),
        .data_oe_o  (oe),
        .int_n_o    (int_n),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .vec_load_i (vec_load),
        .vec_i      (vec_in)
    );

    function automatic logic [7:0] exp_status(input logic ovr_f);
        return {ovr_f, 7'h03};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] got, output logic oe_seen);
        @(negedge clk);
        addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        got = dout; oe_seen = oe;
        @(posedge clk); @(negedge clk);
        iorq_n = 1'b1; rd_n = 1'b1;
        idle(3);
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d, input int hold,
                            output int pulses, output logic [7:0] last);
        pulses = 0; last = 8'h00;
        @(negedge clk);
        addr = a; din = d; iorq_n = 1'b0; wr_n = 1'b0;
        repeat (hold) begin
            @(negedge clk);
            if (tx_valid) begin pulses++; last = tx_data; end
            checks++;
            if (oe !== 1'b0) begin failures++; $display("FAIL R7 oe during write got=%b exp=0", oe); end
        end
        iorq_n = 1'b1; wr_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (tx_valid) begin pulses++; last = tx_data; end
        end
    endtask

    task automatic ack_cycle(input bit with_rx, input logic [7:0] b,
                             output logic [7:0] got, output logic oe_seen);
        @(negedge clk);
        iorq_n = 1'b0; m1_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        got = dout; oe_seen = oe;
        if (with_rx) begin rx_valid = 1'b1; rx_data = b; end
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
        iorq_n = 1'b1; m1_n = 1'b1;
        idle(3);
        m_pend = 1'b0;
        if (with_rx) begin m_buf = b; m_pend = 1'b1; end
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        if (m_pend) m_ovr = 1'b1;
        m_buf = b; m_pend = 1'b1;
    endtask

    task automatic load_vec(input logic [7:0] v);
        @(negedge clk);
        vec_load = 1'b1; vec_in = v;
        @(negedge clk);
        vec_load = 1'b0;
        m_vec = v;
    endtask

    task automatic check_int(input string req);
        check(req, {7'h0, int_n}, {7'h0, !m_pend});
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic       oe_s;
        int         np;
        logic [7:0] last;
        void'($urandom(32'd20240611));

        idle(5);
        // Reset state
        check("R4 reset int_n", {7'h0, int_n}, 8'h01);
        check("R7 reset oe", {7'h0, oe}, 8'h00);
        check("R3 reset tx_valid", {7'h0, tx_valid}, 8'h00);
        rst_n = 1'b1;
        idle(3);

        // R1: status after reset
        io_read(8'h80, got, oe_s);
        check("R1 status", got, exp_status(1'b0));
        check("R7 oe on status read", {7'h0, oe_s}, 8'h01);
        check("R7 oe released", {7'h0, oe}, 8'h00);

        // R6: reset vector on acknowledge
        ack_cycle(1'b0, 8'h00, got, oe_s);
        check("R6 reset vector", got, 8'hFF);
        check("R6 oe on ack", {7'h0, oe_s}, 8'h01);

        // R4: held across a long wait
        rx_push(8'h5A);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            check("R4 int held", {7'h0, int_n}, 8'h00);
        end
        io_read(8'h81, got, oe_s);
        check("R2 data read", got, 8'h5A);
        check_int("R4 read does not ack");
        ack_cycle(1'b0, 8'h00, got, oe_s);
        check_int("R5 ack releases");

        // R8: overrun, then cleared by data read
        rx_push(8'h11);
        rx_push(8'h22);
        io_read(8'h80, got, oe_s);
        check("R8 overrun bit", got, exp_status(1'b1));
        io_read(8'h81, got, oe_s);
        check("R8 newest byte kept", got, 8'h22);
        m_ovr = 1'b0;
        io_read(8'h80, got, oe_s);
        check("R8 overrun cleared", got, exp_status(1'b0));
        ack_cycle(1'b0, 8'h00, got, oe_s);

        // R5: arrival in the same cycle as acknowledge
        rx_push(8'h33);
        ack_cycle(1'b1, 8'hC4, got, oe_s);
        check_int("R5 race keeps pending");
        io_read(8'h80, got, oe_s);
        check("R5 race no overrun", got, exp_status(1'b0));
        io_read(8'h81, got, oe_s);
        check("R5 race new byte", got, 8'hC4);
        ack_cycle(1'b0, 8'h00, got, oe_s);
        check_int("R5 final ack");

        // R9: long write held acts once; R3 data
        io_write(8'h81, 8'hA7, 25, np, last);
        check("R9 single pulse long strobe", np[7:0], 8'd1);
        check("R3 tx byte", last, 8'hA7);

        // R10: status write ignored
        io_write(8'h80, 8'hFF, 5, np, last);
        check("R10 no tx on status write", np[7:0], 8'd0);
        io_read(8'h80, got, oe_s);
        check("R10 status unchanged", got, exp_status(m_ovr));

        // R6: programmed vector
        load_vec(8'h3C);
        ack_cycle(1'b0, 8'h00, got, oe_s);
        check("R6 loaded vector", got, 8'h3C);

        // Random traffic
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [7:0] r;
            op = $urandom_range(0, 7);
            r  = 8'($urandom);
            case (op)
                0: rx_push(r);
                1: begin
                    io_read(8'h80, got, oe_s);
                    check("R1 status random", got, exp_status(m_ovr));
                end
                2: begin
                    io_read(8'h81, got, oe_s);
                    check("R2 data random", got, m_buf);
                    m_ovr = 1'b0;
                end
                3: begin
                    io_write(8'h81, r, 3 + int'($urandom_range(0, 6)), np, last);
                    check("R3 pulse count", np[7:0], 8'd1);
                    check("R3 tx data random", last, r);
                end
                4: begin
                    io_write(8'h80, r, 4, np, last);
                    check("R10 status write random", np[7:0], 8'd0);
                end
                5: begin
                    ack_cycle(($urandom_range(0, 3) == 0), r, got, oe_s);
                    check("R6 vector random", got, m_vec);
                end
                6: begin
                    logic [7:0] a;
                    a = (r[7:1] == 7'h40) ? 8'h10 : r;
                    io_read(a, got, oe_s);
                    check("R7 other address quiet", {7'h0, oe_s}, 8'h00);
                end
                default: load_vec(r);
            endcase
            check_int("R4 int random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule